// File: doc/BRIEF.md
# Four-Port Set/Clear GPIO Register Block

This block is a memory-mapped general-purpose I/O controller with four pin ports behind a simple 32-bit register bus. Ports 0, 1 and 2 are bidirectional banks. Port 3 mixes three kinds of pin: six bidirectional pins, 22 input-only pins and a bank of output-only pins. All of them share a small set of registers, and each kind sits at its own bit positions.

Software never writes an output level, a direction or a mux bit directly. It writes 1s to a set register to raise bits, or to a clear register to lower them. Bits written as 0 are left alone, so several agents can update one port without a read-modify-write. Readable state registers return the stored levels, directions and mux bits. Input-state registers return the pad levels after a two-flop synchroniser.

The bus takes one request per cycle, marked by a valid strobe and a write flag. Read data is registered and appears one cycle after the request.

Top module: `gpio_quad_port`

## Requirements
- R1: After reset every output latch, every output enable and every mux bit is 0, and `bus_rdata_o` is 0.
- R2: A write to a set register raises every addressed bit written as 1. Bits written as 0 keep their value.
- R3: A write to a clear register lowers every addressed bit written as 1. Bits written as 0 keep their value.
- R4: Ports 0 and 1 share one layout, at base 0x040 and 0x060 respectively. Relative to the base, the offsets are: input state +0x00, output set +0x04, output clear +0x08, output state +0x0C, direction set +0x10, direction clear +0x14, direction state +0x18. Pin n of each port is bit n. A direction bit of 1 makes the pin an output.
- R5: Port 2 (pin n at bit n) uses these offsets: direction set 0x010, direction clear 0x014, direction state 0x018, input state 0x01C, output set 0x020, output clear 0x024. Its mux bits (mux bit n at bit n) use set 0x028, clear 0x02C and state 0x030.
- R6: The six port-3 bidirectional pins are controlled at bits 25..30, with pin n at bit n+25. Their output levels are written at 0x004/0x008. Their directions are written through port 2's direction set/clear at 0x010/0x014 and read back at bits 25..30 of 0x018.
- R7: The port-3 output-only pins are set and cleared at bits 0..23 of 0x004/0x008. Their driven levels read back at bits 0..23 of 0x00C, and the bidirectional output levels read back at bits 25..30 of the same register.
- R8: Port-3 input state (0x000) places bidirectional pins 0..4 at bits 10..14 and bidirectional pin 5 at bit 24. The input-only pins 0..9 sit at bits 0..9, pins 10..18 at bits 15..23, and pins 19..21 at bits 25..27.
- R9: A read returns its data on `bus_rdata_o` in the cycle after the request. A pad change is visible only to reads captured at the third rising edge after the change or later.
- R10: Unmapped offsets, write-only offsets and unused bits read as 0. `bus_rdata_o` is 0 in every cycle that does not follow a read.
- R11: Writes to read-only state offsets, and bus cycles without a write, leave every output, enable and mux bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Request strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| p0_in_i | input | P0_W | Port 0 pad inputs |
| p0_out_o | output | P0_W | Port 0 output levels |
| p0_oe_o | output | P0_W | Port 0 output enables |
| p1_in_i | input | P1_W | Port 1 pad inputs |
| p1_out_o | output | P1_W | Port 1 output levels |
| p1_oe_o | output | P1_W | Port 1 output enables |
| p2_in_i | input | P2_W | Port 2 pad inputs |
| p2_out_o | output | P2_W | Port 2 output levels |
| p2_oe_o | output | P2_W | Port 2 output enables |
| p2_mux_o | output | MUX_W | Port 2 stored function-select bits |
| p3_io_in_i | input | 6 | Port 3 bidirectional pad inputs |
| p3_io_out_o | output | 6 | Port 3 bidirectional output levels |
| p3_io_oe_o | output | 6 | Port 3 bidirectional output enables |
| p3_gpi_i | input | 22 | Port 3 input-only pads |
| p3_gpo_o | output | GPO_W | Port 3 output-only levels |

## Verification
The bench builds the block with its default parameters. These are 8, 24 and 13 pins on ports 0 to 2, 24 output-only pins, 3 mux bits and an 8-bit offset. At full width, an all-ones write reaches every pin and every unused high bit, so the reads show the zero padding above each port. With these values the bench can also reach the scattered port-3 input layout, including the hole at bits 10..14 filled by the bidirectional pins and the single bit 24. The defaults also make the port-2 direction register shared with port 3 observable from both sides.

// File: rtl/gpio_qp_pkg.sv
package gpio_qp_pkg;
  localparam int DW = 32;

  // port 3 fixed layout
  localparam int P3_IO_N       = 6;
  localparam int P3_GPI_N      = 22;
  localparam int P3_IO_OUT_LSB = 25;
  localparam int P3_IO_IN_LSB  = 10;
  localparam int P3_IO5_IN_BIT = 24;

  // absolute offsets
  localparam int OFS_P3_IN     = 'h000;
  localparam int OFS_P3_OSET   = 'h004;
  localparam int OFS_P3_OCLR   = 'h008;
  localparam int OFS_P3_OSTATE = 'h00C;
  localparam int OFS_P2_DSET   = 'h010;
  localparam int OFS_P2_DCLR   = 'h014;
  localparam int OFS_P2_DSTATE = 'h018;
  localparam int OFS_P2_IN     = 'h01C;
  localparam int OFS_P2_OSET   = 'h020;
  localparam int OFS_P2_OCLR   = 'h024;
  localparam int OFS_P2_MSET   = 'h028;
  localparam int OFS_P2_MCLR   = 'h02C;
  localparam int OFS_P2_MSTATE = 'h030;
  localparam int OFS_BANK0     = 'h040;
  localparam int OFS_BANK1     = 'h060;

  // offsets inside a uniform bank
  localparam int B_IN     = 'h00;
  localparam int B_OSET   = 'h04;
  localparam int B_OCLR   = 'h08;
  localparam int B_OSTATE = 'h0C;
  localparam int B_DSET   = 'h10;
  localparam int B_DCLR   = 'h14;
  localparam int B_DSTATE = 'h18;

  // bit position of input-only pin i in the port 3 input word
  function automatic int gpi_bit(input int i);
    if (i < 10)      return i;
    else if (i < 19) return i + 5;
    else             return i + 6;
  endfunction

  function automatic logic [DW-1:0] p3_in_word(input logic [P3_IO_N-1:0] io,
                                               input logic [P3_GPI_N-1:0] gpi);
    logic [DW-1:0] w;
    w = '0;
    for (int i = 0; i < P3_GPI_N; i++) w[gpi_bit(i)] = gpi[i];
    for (int j = 0; j < P3_IO_N - 1; j++) w[P3_IO_IN_LSB + j] = io[j];
    w[P3_IO5_IN_BIT] = io[P3_IO_N-1];
    return w;
  endfunction
endpackage

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set wins over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end

  assign q_o = s2;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_qp_pkg::*;
#(
  parameter int W    = 8,
  parameter int AW   = 8,
  parameter int BASE = 'h40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [W-1:0]  pad_in_i,
  output logic [W-1:0]  pad_out_o,
  output logic [W-1:0]  pad_oe_o,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [AW-1:0] A_IN     = AW'(BASE + B_IN);
  localparam logic [AW-1:0] A_OSET   = AW'(BASE + B_OSET);
  localparam logic [AW-1:0] A_OCLR   = AW'(BASE + B_OCLR);
  localparam logic [AW-1:0] A_OSTATE = AW'(BASE + B_OSTATE);
  localparam logic [AW-1:0] A_DSET   = AW'(BASE + B_DSET);
  localparam logic [AW-1:0] A_DCLR   = AW'(BASE + B_DCLR);
  localparam logic [AW-1:0] A_DSTATE = AW'(BASE + B_DSTATE);

  logic [W-1:0] wbits, in_s;

  assign wbits = wdata_i[W-1:0];

  gpio_sc_reg #(.W(W)) u_out (
    .clk_i, .rst_ni,
    .set_i ((wr_i && addr_i == A_OSET) ? wbits : '0),
    .clr_i ((wr_i && addr_i == A_OCLR) ? wbits : '0),
    .q_o   (pad_out_o)
  );

  gpio_sc_reg #(.W(W)) u_dir (
    .clk_i, .rst_ni,
    .set_i ((wr_i && addr_i == A_DSET) ? wbits : '0),
    .clr_i ((wr_i && addr_i == A_DCLR) ? wbits : '0),
    .q_o   (pad_oe_o)
  );

  gpio_sync2 #(.W(W)) u_sync (
    .clk_i, .rst_ni,
    .d_i (pad_in_i),
    .q_o (in_s)
  );

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_IN:     rd_data_o[W-1:0] = in_s;
      A_OSTATE: rd_data_o[W-1:0] = pad_out_o;
      A_DSTATE: rd_data_o[W-1:0] = pad_oe_o;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_quad_port.sv
module gpio_quad_port
  import gpio_qp_pkg::*;
#(
  parameter int AW    = 8,
  parameter int P0_W  = 8,
  parameter int P1_W  = 24,
  parameter int P2_W  = 13,
  parameter int GPO_W = 24,
  parameter int MUX_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [AW-1:0]       bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [P0_W-1:0]     p0_in_i,
  output logic [P0_W-1:0]     p0_out_o,
  output logic [P0_W-1:0]     p0_oe_o,
  input  logic [P1_W-1:0]     p1_in_i,
  output logic [P1_W-1:0]     p1_out_o,
  output logic [P1_W-1:0]     p1_oe_o,
  input  logic [P2_W-1:0]     p2_in_i,
  output logic [P2_W-1:0]     p2_out_o,
  output logic [P2_W-1:0]     p2_oe_o,
  output logic [MUX_W-1:0]    p2_mux_o,
  input  logic [5:0]          p3_io_in_i,
  output logic [5:0]          p3_io_out_o,
  output logic [5:0]          p3_io_oe_o,
  input  logic [21:0]         p3_gpi_i,
  output logic [GPO_W-1:0]    p3_gpo_o
);
  localparam logic [AW-1:0] A_P3_IN     = AW'(OFS_P3_IN);
  localparam logic [AW-1:0] A_P3_OSET   = AW'(OFS_P3_OSET);
  localparam logic [AW-1:0] A_P3_OCLR   = AW'(OFS_P3_OCLR);
  localparam logic [AW-1:0] A_P3_OSTATE = AW'(OFS_P3_OSTATE);
  localparam logic [AW-1:0] A_P2_DSET   = AW'(OFS_P2_DSET);
  localparam logic [AW-1:0] A_P2_DCLR   = AW'(OFS_P2_DCLR);
  localparam logic [AW-1:0] A_P2_DSTATE = AW'(OFS_P2_DSTATE);
  localparam logic [AW-1:0] A_P2_IN     = AW'(OFS_P2_IN);
  localparam logic [AW-1:0] A_P2_OSET   = AW'(OFS_P2_OSET);
  localparam logic [AW-1:0] A_P2_OCLR   = AW'(OFS_P2_OCLR);
  localparam logic [AW-1:0] A_P2_MSET   = AW'(OFS_P2_MSET);
  localparam logic [AW-1:0] A_P2_MCLR   = AW'(OFS_P2_MCLR);
  localparam logic [AW-1:0] A_P2_MSTATE = AW'(OFS_P2_MSTATE);

  logic wr, rd;
  logic [DW-1:0] b0_rd, b1_rd, loc_rd, rdata_q;
  logic [P2_W-1:0] p2_in_s;
  logic [P3_IO_N-1:0] p3_io_in_s, p3_io_w;
  logic [P3_GPI_N-1:0] p3_gpi_s;
  logic unused_wdata;

  assign wr = bus_valid_i & bus_write_i;
  assign rd = bus_valid_i & ~bus_write_i;
  assign p3_io_w = bus_wdata_i[P3_IO_OUT_LSB +: P3_IO_N];
  assign unused_wdata = ^bus_wdata_i;

  // ports 0 and 1 share one layout
  gpio_bank #(.W(P0_W), .AW(AW), .BASE(OFS_BANK0)) u_bank0 (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .pad_in_i(p0_in_i), .pad_out_o(p0_out_o), .pad_oe_o(p0_oe_o), .rd_data_o(b0_rd)
  );

  gpio_bank #(.W(P1_W), .AW(AW), .BASE(OFS_BANK1)) u_bank1 (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .pad_in_i(p1_in_i), .pad_out_o(p1_out_o), .pad_oe_o(p1_oe_o), .rd_data_o(b1_rd)
  );

  // port 2
  gpio_sc_reg #(.W(P2_W)) u_p2_dir (
    .clk_i, .rst_ni,
    .set_i ((wr && bus_addr_i == A_P2_DSET) ? bus_wdata_i[P2_W-1:0] : '0),
    .clr_i ((wr && bus_addr_i == A_P2_DCLR) ? bus_wdata_i[P2_W-1:0] : '0),
    .q_o   (p2_oe_o)
  );

  gpio_sc_reg #(.W(P2_W)) u_p2_out (
    .clk_i, .rst_ni,
    .set_i ((wr && bus_addr_i == A_P2_OSET) ? bus_wdata_i[P2_W-1:0] : '0),
    .clr_i ((wr && bus_addr_i == A_P2_OCLR) ? bus_wdata_i[P2_W-1:0] : '0),
    .q_o   (p2_out_o)
  );

  gpio_sc_reg #(.W(MUX_W)) u_p2_mux (
    .clk_i, .rst_ni,
    .set_i ((wr && bus_addr_i == A_P2_MSET) ? bus_wdata_i[MUX_W-1:0] : '0),
    .clr_i ((wr && bus_addr_i == A_P2_MCLR) ? bus_wdata_i[MUX_W-1:0] : '0),
    .q_o   (p2_mux_o)
  );

  gpio_sync2 #(.W(P2_W)) u_p2_sync (.clk_i, .rst_ni, .d_i(p2_in_i), .q_o(p2_in_s));

  // port 3: direction of bidir pins rides in port 2's direction registers
  gpio_sc_reg #(.W(P3_IO_N)) u_p3_dir (
    .clk_i, .rst_ni,
    .set_i ((wr && bus_addr_i == A_P2_DSET) ? p3_io_w : '0),
    .clr_i ((wr && bus_addr_i == A_P2_DCLR) ? p3_io_w : '0),
    .q_o   (p3_io_oe_o)
  );

  gpio_sc_reg #(.W(P3_IO_N)) u_p3_out (
    .clk_i, .rst_ni,
    .set_i ((wr && bus_addr_i == A_P3_OSET) ? p3_io_w : '0),
    .clr_i ((wr && bus_addr_i == A_P3_OCLR) ? p3_io_w : '0),
    .q_o   (p3_io_out_o)
  );

  gpio_sc_reg #(.W(GPO_W)) u_p3_gpo (
    .clk_i, .rst_ni,
    .set_i ((wr && bus_addr_i == A_P3_OSET) ? bus_wdata_i[GPO_W-1:0] : '0),
    .clr_i ((wr && bus_addr_i == A_P3_OCLR) ? bus_wdata_i[GPO_W-1:0] : '0),
    .q_o   (p3_gpo_o)
  );

  gpio_sync2 #(.W(P3_IO_N))  u_p3_io_sync  (.clk_i, .rst_ni, .d_i(p3_io_in_i), .q_o(p3_io_in_s));
  gpio_sync2 #(.W(P3_GPI_N)) u_p3_gpi_sync (.clk_i, .rst_ni, .d_i(p3_gpi_i),   .q_o(p3_gpi_s));

  always_comb begin
    loc_rd = '0;
    case (bus_addr_i)
      A_P3_IN:     loc_rd = p3_in_word(p3_io_in_s, p3_gpi_s);
      A_P3_OSTATE: begin
        loc_rd[GPO_W-1:0] = p3_gpo_o;
        loc_rd[P3_IO_OUT_LSB +: P3_IO_N] = p3_io_out_o;
      end
      A_P2_DSTATE: begin
        loc_rd[P2_W-1:0] = p2_oe_o;
        loc_rd[P3_IO_OUT_LSB +: P3_IO_N] = p3_io_oe_o;
      end
      A_P2_IN:     loc_rd[P2_W-1:0] = p2_in_s;
      A_P2_MSTATE: loc_rd[MUX_W-1:0] = p2_mux_o;
      default:     loc_rd = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= loc_rd | b0_rd | b1_rd;
    else          rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/gpio_qp_chk.sv
module gpio_qp_chk
  import gpio_qp_pkg::*;
#(
  parameter int AW    = 8,
  parameter int P0_W  = 8,
  parameter int P1_W  = 24,
  parameter int P2_W  = 13,
  parameter int GPO_W = 24,
  parameter int MUX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_valid_i,
  input logic             bus_write_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic [31:0]      bus_rdata_o,
  input logic [P0_W-1:0]  p0_out_o,
  input logic [P0_W-1:0]  p0_oe_o,
  input logic [P1_W-1:0]  p1_out_o,
  input logic [P1_W-1:0]  p1_oe_o,
  input logic [P2_W-1:0]  p2_out_o,
  input logic [P2_W-1:0]  p2_oe_o,
  input logic [MUX_W-1:0] p2_mux_o,
  input logic [5:0]       p3_io_out_o,
  input logic [5:0]       p3_io_oe_o,
  input logic [GPO_W-1:0] p3_gpo_o
);
  logic wr;
  assign wr = bus_valid_i && bus_write_i;

  p_idle_rdata_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && !bus_write_i) |=> bus_rdata_o == 32'h0);

  p_p0_out_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == AW'(OFS_BANK0 + B_OSET)) |=>
      p0_out_o == ($past(p0_out_o) | $past(bus_wdata_i[P0_W-1:0])));

  p_p1_out_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == AW'(OFS_BANK1 + B_OCLR)) |=>
      p1_out_o == ($past(p1_out_o) & ~$past(bus_wdata_i[P1_W-1:0])));

  p_p3_dir_shared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == AW'(OFS_P2_DSET)) |=>
      p3_io_oe_o == ($past(p3_io_oe_o) | $past(bus_wdata_i[30:25])));

  p_gpo_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == AW'(OFS_P3_OSET)) |=>
      p3_gpo_o == ($past(p3_gpo_o) | $past(bus_wdata_i[GPO_W-1:0])));

  p_no_write_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> ($stable(p0_out_o) && $stable(p0_oe_o) && $stable(p1_out_o) &&
             $stable(p1_oe_o) && $stable(p2_out_o) && $stable(p2_oe_o) &&
             $stable(p2_mux_o) && $stable(p3_io_out_o) && $stable(p3_io_oe_o) &&
             $stable(p3_gpo_o)));
endmodule

bind gpio_quad_port gpio_qp_chk #(
  .AW(AW), .P0_W(P0_W), .P1_W(P1_W), .P2_W(P2_W), .GPO_W(GPO_W), .MUX_W(MUX_W)
) u_chk (.*);

// File: tb/tb_gpio_quad_port.sv
`timescale 1ns/1ps
module tb_gpio_quad_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] p0_in = '0, p0_out, p0_oe;
  logic [23:0] p1_in = '0, p1_out, p1_oe;
  logic [12:0] p2_in = '0, p2_out, p2_oe;
  logic [2:0] p2_mux;
  logic [5:0] p3_io_in = '0, p3_io_out, p3_io_oe;
  logic [21:0] p3_gpi = '0;
  logic [23:0] p3_gpo;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_quad_port dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .p0_in_i(p0_in), .p0_out_o(p0_out), .p0_oe_o(p0_oe),
    .p1_in_i(p1_in), .p1_out_o(p1_out), .p1_oe_o(p1_oe),
    .p2_in_i(p2_in), .p2_out_o(p2_out), .p2_oe_o(p2_oe), .p2_mux_o(p2_mux),
    .p3_io_in_i(p3_io_in), .p3_io_out_o(p3_io_out), .p3_io_oe_o(p3_io_oe),
    .p3_gpi_i(p3_gpi), .p3_gpo_o(p3_gpo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 p0 out/oe", {p0_out, p0_oe}, '0);
    chk("R1 p1 out/oe", {p1_out, p1_oe}, '0);
    chk("R1 p2 out/oe/mux", {p2_out, p2_oe, p2_mux}, '0);
    chk("R1 p3 io/gpo", {p3_io_out, p3_io_oe, p3_gpo}, '0);
    chk("R1 rdata", rdata, '0);
    rd_chk("R1 p3 out state", 8'h0C, '0);
    rd_chk("R1 p2 dir state", 8'h18, '0);
    rd_chk("R1 mux state", 8'h30, '0);
  endtask

  task automatic t_bank01;
    bus_wr(8'h44, 32'hA5);
    chk("R2 p0 set", p0_out, 8'hA5);
    bus_wr(8'h44, 32'h0F);
    chk("R2 p0 set keeps zeros", p0_out, 8'hAF);
    bus_wr(8'h48, 32'h81);
    chk("R3 p0 clr", p0_out, 8'h2E);
    rd_chk("R4 p0 out state", 8'h4C, 32'h2E);
    bus_wr(8'h50, 32'h3C);
    chk("R4 p0 dir set", p0_oe, 8'h3C);
    bus_wr(8'h54, 32'h24);
    rd_chk("R4 p0 dir state", 8'h58, 32'h18);
    bus_wr(8'h64, 32'hFFFF_FFFF);
    chk("R2 p1 set all", p1_out, 24'hFF_FFFF);
    rd_chk("R10 p1 unused bits", 8'h6C, 32'h00FF_FFFF);
    bus_wr(8'h68, 32'h00F0_000F);
    chk("R3 p1 clr", p1_out, 24'h0F_FFF0);
    bus_wr(8'h70, 32'h0080_0001);
    rd_chk("R4 p1 dir state", 8'h78, 32'h0080_0001);
    chk("R4 p0 untouched by p1", {p0_out, p0_oe}, {8'h2E, 8'h18});
  endtask

  task automatic t_port2;
    bus_wr(8'h10, 32'h0000_1FFF);
    chk("R5 p2 dir set", p2_oe, 13'h1FFF);
    chk("R6 p3 dir untouched", p3_io_oe, 6'h0);
    bus_wr(8'h20, 32'hFFFF_1234);
    chk("R5 p2 out set", p2_out, 13'h1234);
    bus_wr(8'h24, 32'h0000_0204);
    chk("R5 p2 out clr", p2_out, 13'h1030);
    bus_wr(8'h28, 32'h5);
    chk("R5 mux set", p2_mux, 3'h5);
    bus_wr(8'h2C, 32'h1);
    rd_chk("R5 mux state", 8'h30, 32'h4);
    bus_wr(8'h14, 32'h0000_0F00);
    rd_chk("R5 p2 dir state", 8'h18, 32'h0000_10FF);
  endtask

  task automatic t_port3;
    bus_wr(8'h04, 32'h7E00_0001);
    chk("R6 p3 io out set", p3_io_out, 6'h3F);
    chk("R7 gpo set", p3_gpo, 24'h00_0001);
    bus_wr(8'h08, 32'h0200_0000);
    chk("R6 p3 io out clr", p3_io_out, 6'h3E);
    bus_wr(8'h04, 32'h00AB_CDE0);
    chk("R7 gpo or", p3_gpo, 24'hAB_CDE1);
    bus_wr(8'h08, 32'h00F0_0001);
    rd_chk("R7 p3 out state", 8'h0C, 32'h7C0B_CDE0);
    bus_wr(8'h10, 32'h4200_0000);
    chk("R6 p3 dir via p2 set", p3_io_oe, 6'h21);
    chk("R6 p2 dir unchanged", p2_oe, 13'h10FF);
    rd_chk("R6 shared dir state", 8'h18, 32'h4200_10FF);
    bus_wr(8'h14, 32'h4000_0000);
    chk("R6 p3 dir via p2 clr", p3_io_oe, 6'h01);
  endtask

  task automatic t_inputs;
    logic [31:0] d, exp3;
    p0_in = 8'h5A; p1_in = 24'h12_3456; p2_in = 13'h0ABC;
    p3_io_in = 6'b100101; p3_gpi = 22'h2A_5C3F;
    exp3 = {4'b0, p3_gpi[21:19], p3_io_in[5], p3_gpi[18:10], p3_io_in[4:0], p3_gpi[9:0]};
    bus_rd(8'h40, d);
    chk("R9 first edge still old", d, 32'h0);
    bus_rd(8'h40, d);
    chk("R9 second edge still old", d, 32'h0);
    bus_rd(8'h40, d);
    chk("R9 third edge new", d, 32'h5A);
    rd_chk("R4 p1 input", 8'h60, 32'h0012_3456);
    rd_chk("R5 p2 input", 8'h1C, 32'h0000_0ABC);
    rd_chk("R8 p3 input map", 8'h00, exp3);
    p3_io_in = 6'b011010; p3_gpi = 22'h15_A3C0;
    exp3 = {4'b0, p3_gpi[21:19], p3_io_in[5], p3_gpi[18:10], p3_io_in[4:0], p3_gpi[9:0]};
    repeat (3) @(negedge clk);
    rd_chk("R8 p3 input map 2", 8'h00, exp3);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    bus_wr(8'h4C, 32'hFFFF_FFFF);
    bus_wr(8'h58, 32'hFFFF_FFFF);
    bus_wr(8'h40, 32'hFFFF_FFFF);
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h30, 32'hFFFF_FFFF);
    bus_wr(8'h7C, 32'hFFFF_FFFF);
    chk("R11 p0 after ro writes", {p0_out, p0_oe}, {8'h2E, 8'h18});
    chk("R11 p3 after ro writes", {2'b0, p3_io_out, 2'b0, p3_io_oe, 8'h0, p3_gpo}[31:0],
        {2'b0, 6'h3E, 2'b0, 6'h01, 8'h0, 24'h0B_CDE0}[31:0]);
    chk("R11 p2 after ro writes", {p2_out, p2_oe, p2_mux}, {13'h1030, 13'h10FF, 3'h4});
    rd_chk("R10 unmapped 0x34", 8'h34, '0);
    rd_chk("R10 unmapped 0x7C", 8'h7C, '0);
    rd_chk("R10 write-only 0x04", 8'h04, '0);
    bus_rd(8'h4C, d);
    chk("R9 read data", d, 32'h2E);
    @(negedge clk);
    chk("R10 rdata idle zero", rdata, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bank01();
    t_port2();
    t_port3();
    t_inputs();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule